// File: doc/BRIEF.md
# Transmit Overhead Byte Overwrite Unit

This unit sits in the byte-wide transmit path of a SONET/SDH section terminator. An upstream framer marks each byte with an overhead flag and a position: row, overhead column, and the interleaved STS slot. The unit can swap selected transport overhead bytes for values held in its own registers, and it passes every other byte through unchanged. One pipeline register sits between input and output. Because of that register, downstream scrambling and parity logic always see a fixed one-cycle delay.

The unit holds one replacement register for each of the 27 transport overhead bytes of the first STS slot. These cover all nine rows (both section and line overhead rows) and the three overhead columns. Each register has a hold-off bit. When the bit is set, the byte at that location goes through untouched. When it is clear, the stored value replaces the byte. A separate global monitor bit makes the whole unit non-intrusive. The rest of the transmit chain selects the data source, for example a locally built alarm stream, so overwriting works the same whatever that source is. Software must load every register through the write port before traffic starts, because the registers have no reset value.

Top module: `tx_oh_insert`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly one clock. While `rst` is high at a clock edge, `out_valid` becomes 0.
- R2: A location is selected only when all of the following hold in the same cycle: `in_valid`=1, `in_oh`=1, `in_sts`=0, `in_row`<9 and `in_col`<3. The selected location's register index is `in_row*3+in_col`. If that register's hold-off bit `cfg_data[8]` was written as 0, `out_byte` one cycle later equals the stored `cfg_data[7:0]`.
- R3: When the selected location's hold-off bit is 1, `out_byte` one cycle later equals `in_byte`.
- R4: Bytes are never altered in any of these cases: `in_oh`=0, `in_sts`≠0, `in_row`≥9 or `in_col`≥3. The stored registers have no effect on such bytes.
- R5: A write to address 27 sets the global monitor bit from `cfg_data[0]`. While this bit is 1, no byte is altered, whatever the hold-off bits say. Writing it back to 0 brings the per-location behaviour back.
- R6: Suppose a register write lands in the same cycle as the byte at its location. That byte uses the value held before the write. The new value applies from the next time that location occurs.
- R7: `rst` does not change the replacement registers or the monitor bit.
- R8: Writes to addresses 28 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte present |
| in_byte | input | 8 | Input frame byte |
| in_oh | input | 1 | Byte lies in a transport overhead column |
| in_row | input | 4 | Frame row, 0 to 8 |
| in_col | input | 2 | Overhead column within the STS slot, 0 to 2 |
| in_sts | input | 6 | Interleaved STS slot index |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address: 0..26 locations, 27 monitor bit |
| cfg_data | input | 9 | Bit 8 hold-off, bits 7:0 replacement value (bit 0 for address 27) |
| out_valid | output | 1 | Output byte present |
| out_byte | output | 8 | Output frame byte |

## Verification
The assertions rely on two conditions. First, the framer never marks a position that matches more than one location. Second, every register has been written before the first valid byte, so the stored values and the monitor bit are never unknown when they are used. The stimulus keeps to both conditions. It writes all 27 locations and the monitor bit straight after reset and before any traffic. It also drives positions only from whole row, column and slot indices, so at most one location can match in a cycle.

// File: rtl/tx_ohi_pkg.sv
package tx_ohi_pkg;
  // One replacement register entry: hold-off flag and the byte to insert.
  typedef struct packed {
    logic       hold;
    logic [7:0] val;
  } ohreg_t;

  // Register index of an overhead byte: row-major across the overhead columns.
  function automatic int loc_index(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction
endpackage

// File: rtl/ohi_locmatch.sv
module ohi_locmatch #(
  parameter int ROWS       = 9,
  parameter int OHCOLS     = 3,
  parameter int ROW_W      = 4,
  parameter int COL_W      = 2,
  parameter int STS_W      = 6,
  parameter int TARGET_STS = 0,
  localparam int LOCS      = ROWS * OHCOLS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             oh,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [STS_W-1:0] sts,
  output logic [LOCS-1:0]  hit_vec
);
  import tx_ohi_pkg::*;

  logic slot_ok;
  assign slot_ok = valid && oh && (sts == STS_W'(TARGET_STS));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < OHCOLS; c++) begin : g_col
      assign hit_vec[loc_index(r, c, OHCOLS)] =
        slot_ok && (row == ROW_W'(r)) && (col == COL_W'(c));
    end
  end

  // R2: a position selects at most one location
  assert_single_hit_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  // R4: payload bytes never select a location
  assert_payload_nohit_R4: assert property (@(posedge clk) disable iff (rst)
    (!oh || !valid) |-> (hit_vec == '0));
endmodule

// File: rtl/ohi_regfile.sv
module ohi_regfile #(
  parameter int LOCS = 27,
  parameter int AW   = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [AW-1:0]  addr,
  input  logic [8:0]     data,
  input  logic [LOCS-1:0] hit_vec,
  output logic           replace,
  output logic [7:0]     sel_val,
  output logic           monitor_on,
  output logic           hit_held
);
  import tx_ohi_pkg::*;

  localparam logic [AW-1:0] CTRL_ADDR = AW'(LOCS);

  ohreg_t regs [LOCS];
  logic   mon_q;

  // Contents survive reset on purpose; software loads them before traffic.
  always_ff @(posedge clk) begin
    if (we && (addr < CTRL_ADDR)) regs[addr] <= ohreg_t'(data);
    if (we && (addr == CTRL_ADDR)) mon_q <= data[0];
  end

  logic any_hit;
  always_comb begin
    sel_val  = '0;
    hit_held = 1'b0;
    any_hit  = 1'b0;
    for (int i = 0; i < LOCS; i++) begin
      if (hit_vec[i]) begin
        sel_val  = sel_val | regs[i].val;
        hit_held = hit_held | regs[i].hold;
        any_hit  = 1'b1;
      end
    end
  end

  assign monitor_on = mon_q;
  assign replace    = any_hit && !hit_held && !mon_q;

  // R5: monitor mode never asks for a replacement
  assert_monitor_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    monitor_on |-> !replace);
endmodule

// File: rtl/tx_oh_insert.sv
module tx_oh_insert #(
  parameter int ROWS       = 9,
  parameter int OHCOLS     = 3,
  parameter int STS_N      = 48,
  parameter int TARGET_STS = 0,
  localparam int LOCS      = ROWS * OHCOLS,
  localparam int ROW_W     = $clog2(ROWS + 7),
  localparam int COL_W     = $clog2(OHCOLS + 1),
  localparam int STS_W     = $clog2(STS_N),
  localparam int AW        = $clog2(LOCS + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  input  logic             in_oh,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic [STS_W-1:0] in_sts,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [8:0]       cfg_data,
  output logic             out_valid,
  output logic [7:0]       out_byte
);
  logic [LOCS-1:0] hit_vec;
  logic            replace;
  logic [7:0]      sel_val;
  logic            monitor_on;
  logic            hit_held;

  ohi_locmatch #(
    .ROWS(ROWS), .OHCOLS(OHCOLS), .ROW_W(ROW_W), .COL_W(COL_W),
    .STS_W(STS_W), .TARGET_STS(TARGET_STS)
  ) u_match (
    .clk(clk), .rst(rst), .valid(in_valid), .oh(in_oh),
    .row(in_row), .col(in_col), .sts(in_sts), .hit_vec(hit_vec)
  );

  ohi_regfile #(.LOCS(LOCS), .AW(AW)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .data(cfg_data),
    .hit_vec(hit_vec), .replace(replace), .sel_val(sel_val),
    .monitor_on(monitor_on), .hit_held(hit_held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      out_byte  <= replace ? sel_val : in_byte;
    end
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid));

  assert_monitor_pass_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && monitor_on) |=> (out_byte == $past(in_byte)));

  assert_payload_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_oh) |=> (out_byte == $past(in_byte)));

  assert_hold_pass_R3: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != '0 && hit_held) |=> (out_byte == $past(in_byte)));

  assert_insert_value_R2: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != '0 && !hit_held && !monitor_on) |=> (out_byte == $past(sel_val)));
endmodule

// File: tb/tx_oh_insert_tb.sv
module tx_oh_insert_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_oh = 1'b0;
  logic [3:0] in_row = '0;
  logic [1:0] in_col = '0;
  logic [5:0] in_sts = '0;
  logic       cfg_we = 1'b0;
  logic [4:0] cfg_addr = '0;
  logic [8:0] cfg_data = '0;
  logic       out_valid;
  logic [7:0] out_byte;

  tx_oh_insert u_dut (.*);

  always #2.5 clk = ~clk;

  typedef struct {
    int         cyc;
    logic       v;
    logic [7:0] b;
    string      tag;
  } exp_t;

  exp_t       q[$];
  int         cnt = 0;
  int         checks = 0;
  int         errors = 0;
  logic [8:0] m_reg [27];
  logic       m_mon = 1'b0;

  always @(posedge clk) cnt <= cnt + 1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: compares each design output with the queued expectation.
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc < cnt) begin
      exp_t e;
      e = q.pop_front();
      chk(out_valid == e.v, {e.tag, " valid"}, int'(out_valid), int'(e.v));
      if (e.v) chk(out_byte == e.b, e.tag, int'(out_byte), int'(e.b));
    end
  end

  // Driver: one byte cycle plus an optional register write in the same cycle.
  task automatic cyc(input logic v, input logic oh, input int r, input int c,
                     input int s, input logic [7:0] b, input logic we,
                     input int a, input logic [8:0] d, input string tag);
    logic [7:0] e;
    int idx;
    @(negedge clk);
    in_valid = v; in_oh = oh; in_row = 4'(r); in_col = 2'(c); in_sts = 6'(s);
    in_byte = b; cfg_we = we; cfg_addr = 5'(a); cfg_data = d;
    e = b;
    idx = r * 3 + c;
    if (v && oh && s == 0 && r < 9 && c < 3 && !m_mon && !m_reg[idx][8])
      e = m_reg[idx][7:0];
    q.push_back('{cnt, v, e, tag});
    if (we) begin
      if (a < 27) m_reg[a] = d;
      else if (a == 27) m_mon = d[0];
    end
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 0, 0, 0, 8'h00, 1'b0, 0, 9'h0, tag);
  endtask

  task automatic wr(input int a, input logic [8:0] d, input string tag);
    cyc(1'b0, 1'b0, 0, 0, 0, 8'h00, 1'b1, a, d, tag);
  endtask

  task automatic sweep(input int s, input logic [7:0] base, input string tag);
    for (int r = 0; r < 9; r++)
      for (int c = 0; c < 3; c++)
        cyc(1'b1, 1'b1, r, c, s, 8'(base + r * 3 + c), 1'b0, 0, 9'h0, tag);
  endtask

  task automatic do_reset();
    idle("R1"); idle("R1");
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; cfg_we = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
    end
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
    rst = 1'b0;
    // load every register with hold-off set, monitor bit off
    for (int i = 0; i < 27; i++) wr(i, {1'b1, 8'(8'hA0 + i)}, "R3");
    wr(27, 9'h000, "R5");
    sweep(0, 8'h10, "R3 all held");
    // enable even locations
    for (int i = 0; i < 27; i += 2) wr(i, {1'b0, 8'(8'h40 + i)}, "R2");
    sweep(0, 8'h10, "R2 mixed");
    sweep(1, 8'h60, "R4 other slot");
    sweep(47, 8'h70, "R4 last slot");
    for (int r = 0; r < 9; r++)
      cyc(1'b1, 1'b0, r, 0, 0, 8'(8'hC0 + r), 1'b0, 0, 9'h0, "R4 payload");
    cyc(1'b1, 1'b1, 12, 0, 0, 8'h5A, 1'b0, 0, 9'h0, "R4 row range");
    cyc(1'b1, 1'b1, 0, 3, 0, 8'h5B, 1'b0, 0, 9'h0, "R4 col range");
    idle("R1 gap");
    cyc(1'b1, 1'b1, 0, 0, 0, 8'h11, 1'b0, 0, 9'h0, "R1 after gap");
    // monitor bit
    wr(27, 9'h001, "R5");
    sweep(0, 8'h20, "R5 monitor on");
    wr(27, 9'h000, "R5");
    sweep(0, 8'h20, "R5 monitor off");
    // same-cycle write: row 1 col 1 -> index 4
    cyc(1'b1, 1'b1, 1, 1, 0, 8'h33, 1'b1, 4, {1'b0, 8'hE4}, "R6 old value");
    cyc(1'b1, 1'b1, 1, 1, 0, 8'h34, 1'b0, 0, 9'h0, "R6 new value");
    cyc(1'b1, 1'b1, 2, 2, 0, 8'h35, 1'b1, 8, {1'b1, 8'h00}, "R6 old value");
    cyc(1'b1, 1'b1, 2, 2, 0, 8'h36, 1'b0, 0, 9'h0, "R6 held now");
    // out-of-range addresses
    for (int a = 28; a < 32; a++) wr(a, {1'b0, 8'hFF}, "R8");
    sweep(0, 8'h80, "R8 no change");
    // reset keeps contents
    wr(27, 9'h001, "R7");
    do_reset();
    sweep(0, 8'h90, "R7 monitor kept");
    wr(27, 9'h000, "R7");
    do_reset();
    sweep(0, 8'h90, "R7 regs kept");
    repeat (4) idle("R1 drain");
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=done", cnt);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule